// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of a multi-channel event timer. It watches a shared free-running main counter, compares it with its own comparator, and raises a one-cycle interrupt pulse on one of 32 interrupt lines when the counter reaches that comparator. In one-shot mode it fires once per arming. In periodic mode it adds a programmed period to the comparator after every event, so the channel keeps firing at a fixed interval. A 32-bit mode limits the comparator, the period and every comparison to the low 32 bits and uses wrap-safe arithmetic. In that mode a one-shot channel also fires when the low counter word passes 0xFFFFFFFF.

A surrounding register block owns the address decode. It presents a word select, write strobe and write data to the channel and reads the channel's words back combinationally. The global enable and legacy-routing bits and the main counter value are inputs to the channel. The channel is armed by a comparator write while the global enable is high. It is also armed when the global enable rises, provided its comparator is not all ones. It is disarmed while the global enable is low.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the config word (select 0) reads 0x18 (bit 3 periodic-capable and bit 4 wide-capable set, all else 0), the capability word (select 1) reads 0x00000C20, both comparator words (select 2 low, select 3 high) read 0xFFFFFFFF, and no interrupt line is active.
- R2: In one-shot mode (config bit 2 clear) an armed channel pulses its line once in the cycle after the counter equals the comparator, and not again.
- R3: In periodic mode (config bit 2 set) each event adds the period to the comparator, so pulses repeat every period ticks and the comparator read back holds the next event time.
- R4: In periodic mode a comparator-low write loads only the period when the set-value bit (config bit 5) is clear, and loads both comparator and period when it is set. The set-value bit reads back 0 after any write to either comparator word.
- R5: A period write clears the period's top bit: bit 31 in 32-bit mode, bit 63 in 64-bit mode.
- R6: Setting the 32-bit mode bit (config bit 6) zeroes the comparator's upper word. Comparator-high writes are then ignored, and matches ignore the counter's upper word.
- R7: In 32-bit one-shot mode an armed channel also pulses when the low counter word is 0xFFFFFFFF, once per arming. When that is also the comparator match, only a single pulse results.
- R8: The line is the 5-bit route field (config bits 11:7). When the legacy input is high, channel 0 uses line 0 and channel 1 uses line 8 regardless of the route.
- R9: No pulse is emitted unless both the channel enable (config bit 1) and the global enable are set.
- R10: Writes to the capability word are ignored, and config bits 3 and 4 stay set whatever is written.
- R11: A rising global enable arms the channel only when its comparator is not all ones. An armed comparator already in the past fires at once.
- R12: The interrupt output has at most one line active, and each event drives it for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_count | input | 64 | Shared main counter value |
| glb_en | input | 1 | Global enable of counter and interrupts |
| glb_legacy | input | 1 | Legacy routing override |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Word select: 0 config, 1 capability, 2 comparator low, 3 comparator high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq_out | output | 32 | One-hot interrupt pulse vector |

## Verification
The wraparound pulse and the comparator match of a 32-bit one-shot channel can fall in the same cycle, when the comparator low word is 0xFFFFFFFF. The bench places the counter just below the wrap point, programs that comparator, and steps across the wrap. It then requires exactly one active line in the match cycle, a quiet output in the next cycle, and no second pulse after that. Separately, a periodic event and a comparator-low write are kept apart in time, so that each pulse can be attributed to the period that was programmed.

// File: rtl/cmp_timer_chan_pkg.sv
package cmp_timer_chan_pkg;

  // config word bit positions
  localparam int CFG_EN_B   = 1;
  localparam int CFG_PER_B  = 2;
  localparam int CFG_PCAP_B = 3;
  localparam int CFG_WCAP_B = 4;
  localparam int CFG_SETV_B = 5;
  localparam int CFG_M32_B  = 6;
  localparam int CFG_RT_LSB = 7;
  localparam int RT_W       = 5;

  typedef enum logic [2:0] {
    SEL_CFG    = 3'd0,
    SEL_CAP    = 3'd1,
    SEL_CMP_LO = 3'd2,
    SEL_CMP_HI = 3'd3
  } word_sel_e;

  typedef struct packed {
    logic [RT_W-1:0] route;
    logic            m32;
    logic            per;
    logic            en;
  } chan_cfg_t;

endpackage

// File: rtl/chan_regs.sv
module chan_regs
  import cmp_timer_chan_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] CAP_WORD = 32'h0000_0C20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [DW-1:0]     wdata,
  input  logic              adv,
  output chan_cfg_t         cfg,
  output logic [2*DW-1:0]   cmp,
  output logic              cmp_wr,
  output logic [DW-1:0]     rdata
);
  localparam int CW = 2 * DW;

  logic            en_q, en_d, per_q, per_d, setv_q, setv_d, m32_q, m32_d;
  logic [RT_W-1:0] rt_q, rt_d;
  logic [CW-1:0]   cmp_q, cmp_d, prd_q, prd_d;
  logic            wr_cfg, wr_lo, wr_hi, ld_en;
  word_sel_e       sel_e;

  assign sel_e  = word_sel_e'(sel);
  assign wr_cfg = we && (sel_e == SEL_CFG);
  assign wr_lo  = we && (sel_e == SEL_CMP_LO);
  assign wr_hi  = we && (sel_e == SEL_CMP_HI);
  assign ld_en  = wr_cfg || wr_lo || wr_hi || adv;

  always_comb begin
    en_d   = en_q;
    per_d  = per_q;
    setv_d = setv_q;
    m32_d  = m32_q;
    rt_d   = rt_q;
    cmp_d  = cmp_q;
    prd_d  = prd_q;
    if (adv) begin
      if (m32_q) cmp_d = {{DW{1'b0}}, cmp_q[DW-1:0] + prd_q[DW-1:0]};
      else       cmp_d = cmp_q + prd_q;
    end
    if (wr_cfg) begin
      en_d   = wdata[CFG_EN_B];
      per_d  = wdata[CFG_PER_B];
      setv_d = wdata[CFG_SETV_B];
      m32_d  = wdata[CFG_M32_B];
      rt_d   = wdata[CFG_RT_LSB +: RT_W];
      if (wdata[CFG_M32_B]) begin
        cmp_d[CW-1:DW] = '0;
        prd_d[CW-1:DW] = '0;
      end
    end
    if (wr_lo) begin
      if (!per_q || setv_q) cmp_d[DW-1:0] = wdata;
      if (per_q) begin
        if (m32_q) prd_d[DW-1:0] = {1'b0, wdata[DW-2:0]};
        else       prd_d[DW-1:0] = wdata;
      end
      setv_d = 1'b0;
    end
    if (wr_hi) begin
      if (!m32_q) begin
        if (!per_q || setv_q) cmp_d[CW-1:DW] = wdata;
        else                  prd_d[CW-1:DW] = {1'b0, wdata[DW-2:0]};
      end
      setv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      setv_q <= 1'b0;
      m32_q  <= 1'b0;
      rt_q   <= '0;
      cmp_q  <= '1;
      prd_q  <= '0;
    end else if (ld_en) begin
      en_q   <= en_d;
      per_q  <= per_d;
      setv_q <= setv_d;
      m32_q  <= m32_d;
      rt_q   <= rt_d;
      cmp_q  <= cmp_d;
      prd_q  <= prd_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel_e)
      SEL_CFG: begin
        rdata[CFG_EN_B]              = en_q;
        rdata[CFG_PER_B]             = per_q;
        rdata[CFG_PCAP_B]            = 1'b1;
        rdata[CFG_WCAP_B]            = 1'b1;
        rdata[CFG_SETV_B]            = setv_q;
        rdata[CFG_M32_B]             = m32_q;
        rdata[CFG_RT_LSB +: RT_W]    = rt_q;
      end
      SEL_CAP:    rdata = CAP_WORD[DW-1:0];
      SEL_CMP_LO: rdata = cmp_q[DW-1:0];
      SEL_CMP_HI: rdata = cmp_q[CW-1:DW];
      default:    rdata = '0;
    endcase
  end

  assign cfg    = '{route: rt_q, m32: m32_q, per: per_q, en: en_q};
  assign cmp    = cmp_q;
  assign cmp_wr = wr_lo || wr_hi;

  AST_SETVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |=> !setv_q); // R4
  AST_PERIOD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && per_q && m32_q && !setv_q) |=> !prd_q[DW-1]); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    m32_q |-> (cmp_q[CW-1:DW] == '0)); // R6

endmodule

// File: rtl/chan_match.sv
module chan_match #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] count,
  input  logic [2*DW-1:0] cmp,
  input  logic            per,
  input  logic            m32,
  input  logic            glb_en,
  input  logic            cmp_wr,
  output logic            fire,
  output logic            adv
);
  localparam int CW = 2 * DW;

  logic          glb_q, armed_q, armed_d, catch_q, catch_d, wrap_q, wrap_d;
  logic [CW-1:0] diff;
  logic          reached, eq, glb_rise, arm_set, match_ev, wrap_ev;

  assign diff     = count - cmp;
  assign reached  = m32 ? !diff[DW-1] : !diff[CW-1];
  assign eq       = m32 ? (diff[DW-1:0] == '0) : (diff == '0);
  assign glb_rise = glb_en && !glb_q;
  assign arm_set  = (cmp_wr && glb_en) || (glb_rise && (cmp != '1));

  // an exact hit always fires; a passed comparator fires only when not catching up
  assign match_ev = armed_q && (eq || (reached && !catch_q));
  assign wrap_ev  = armed_q && m32 && !per && !wrap_q && !match_ev &&
                    (count[DW-1:0] == '1);
  assign fire     = match_ev || wrap_ev;
  assign adv      = armed_q && per && reached;

  always_comb begin
    armed_d = armed_q;
    catch_d = catch_q;
    wrap_d  = wrap_q;
    if (!glb_en) begin
      armed_d = 1'b0;
    end else if (arm_set) begin
      armed_d = 1'b1;
      catch_d = 1'b0;
      wrap_d  = 1'b0;
    end else begin
      if (match_ev && !per) armed_d = 1'b0;
      if (match_ev && per)  catch_d = 1'b1;
      else if (!reached)    catch_d = 1'b0;
      if (wrap_ev)          wrap_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q   <= 1'b0;
      armed_q <= 1'b0;
      catch_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      glb_q   <= glb_en;
      armed_q <= armed_d;
      catch_q <= catch_d;
      wrap_q  <= wrap_d;
    end
  end

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && !per && !arm_set) |=> !armed_q); // R2
  AST_WRAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !arm_set) |=> !wrap_ev); // R7
  AST_OFF_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !fire); // R9

endmodule

// File: rtl/chan_irq_route.sv
module chan_irq_route
  import cmp_timer_chan_pkg::*;
#(
  parameter int NL      = 32,
  parameter int CHAN_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            en,
  input  logic            glb_en,
  input  logic            legacy,
  input  logic [RT_W-1:0] route,
  output logic [NL-1:0]   irq
);
  localparam int LW = $clog2(NL);

  logic          has_leg;
  logic [LW-1:0] leg_line, line;
  logic [NL-1:0] irq_q, irq_d;

  generate
    if (CHAN_ID == 0) begin : g_leg_ch0
      assign has_leg  = 1'b1;
      assign leg_line = LW'(0);
    end else if (CHAN_ID == 1) begin : g_leg_ch1
      assign has_leg  = 1'b1;
      assign leg_line = LW'(8);
    end else begin : g_leg_none
      assign has_leg  = 1'b0;
      assign leg_line = '0;
    end
  endgenerate

  assign line = (legacy && has_leg) ? leg_line : LW'(route);

  always_comb begin
    irq_d = '0;
    if (fire && en && glb_en) irq_d[line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q)); // R12
  AST_IRQ_NEEDS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q != '0) |-> $past(glb_en)); // R9

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_chan_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          NL       = 32,
  parameter int          CHAN_ID  = 0,
  parameter logic [31:0] CAP_WORD = 32'h0000_0C20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] main_count,
  input  logic            glb_en,
  input  logic            glb_legacy,
  input  logic            reg_we,
  input  logic [2:0]      reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NL-1:0]   irq_out
);
  chan_cfg_t       cfg;
  logic [2*DW-1:0] cmp;
  logic            cmp_wr, fire, adv;

  chan_regs #(.DW(DW), .CAP_WORD(CAP_WORD)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .adv(adv), .cfg(cfg), .cmp(cmp), .cmp_wr(cmp_wr), .rdata(reg_rdata)
  );

  chan_match #(.DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n), .count(main_count), .cmp(cmp), .per(cfg.per),
    .m32(cfg.m32), .glb_en(glb_en), .cmp_wr(cmp_wr), .fire(fire), .adv(adv)
  );

  chan_irq_route #(.NL(NL), .CHAN_ID(CHAN_ID)) u_route (
    .clk(clk), .rst_n(rst_n), .fire(fire), .en(cfg.en), .glb_en(glb_en),
    .legacy(glb_legacy), .route(cfg.route), .irq(irq_out)
  );

endmodule

// File: tb/sim_cmp_timer_chan.sv
module sim_cmp_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        glb_en, glb_legacy, reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cmp_timer_chan #(.CHAN_ID(1)) u0 (
    .clk(clk), .rst_n(rst_n), .main_count(cnt), .glb_en(glb_en),
    .glb_legacy(glb_legacy), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // {config word[11:0], legacy, expected line[4:0]}
  localparam logic [17:0] VEC [5] = '{
    {12'h282, 1'b0, 5'd5},
    {12'h502, 1'b0, 5'd10},
    {12'hF82, 1'b0, 5'd31},
    {12'h182, 1'b1, 5'd8},
    {12'h002, 1'b0, 5'd0}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic step_to(input logic [63:0] v);
    cnt = v;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c;
    rst_n = 1'b0; cnt = '0; glb_en = 1'b0; glb_legacy = 1'b0;
    reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, r); chk("R1 cfg", r, 32'h18);
    rd(1, r); chk("R1 cap", r, 32'hC20);
    rd(2, r); chk("R1 cmp lo", r, 32'hFFFF_FFFF);
    rd(3, r); chk("R1 cmp hi", r, 32'hFFFF_FFFF);
    chk("R1 irq", irq_out, 0);

    // R10 read-only words
    wr(1, 32'h0); rd(1, r); chk("R10 cap", r, 32'hC20);
    wr(0, 32'h0); rd(0, r); chk("R10 cfg ro bits", r, 32'h18);

    // R11 global enable rise with all-ones comparator does not arm
    wr(0, 32'h282);
    glb_en = 1'b1;
    step_to(1); step_to(2); step_to(3);
    chk("R11 no arm", irq_out, 0);

    wr(3, 32'h0);
    // R2 / R8 / R12 table walk
    foreach (VEC[i]) begin
      glb_legacy = VEC[i][5];
      wr(0, {20'h0, VEC[i][17:6]});
      c = cnt;
      wr(2, c[31:0] + 32'd3);
      step_to(c + 1); chk("R2 early", irq_out, 0);
      step_to(c + 2);
      step_to(c + 3); chk("R8 line", irq_out, 32'h1 << VEC[i][4:0]);
      step_to(c + 4); chk("R12 one cycle", irq_out, 0);
      step_to(c + 5); chk("R2 once", irq_out, 0);
    end
    glb_legacy = 1'b0;

    // R9 channel enable gating
    wr(0, 32'h280);
    c = cnt; wr(2, c[31:0] + 32'd2);
    step_to(c + 1); step_to(c + 2); chk("R9 chan off", irq_out, 0);
    // R9 global enable gating, then R11 re-arm on rise
    wr(0, 32'h282);
    c = cnt; wr(2, c[31:0] + 32'd2);
    step_to(c + 1);
    glb_en = 1'b0;
    step_to(c + 2); chk("R9 glb off", irq_out, 0);
    glb_en = 1'b1;
    step_to(c + 3);
    step_to(c + 4); chk("R11 rearm fires", irq_out, 32'h20);
    step_to(c + 5); chk("R11 once", irq_out, 0);

    // R3 / R4 periodic
    wr(0, 32'h2A6);
    c = cnt;
    wr(2, c[31:0] + 32'd2);
    wr(2, 32'd4);
    rd(2, r); chk("R4 cmp kept", r, c[31:0] + 32'd2);
    rd(0, r); chk("R4 setval cleared", r, 32'h29E);
    step_to(c + 1); chk("R3 early", irq_out, 0);
    step_to(c + 2); chk("R3 first", irq_out, 32'h20);
    step_to(c + 3); step_to(c + 4); step_to(c + 5); chk("R3 gap", irq_out, 0);
    step_to(c + 6); chk("R3 second", irq_out, 32'h20);
    step_to(c + 7); step_to(c + 8); step_to(c + 9);
    rd(2, r); chk("R3 cmp advanced", r, c[31:0] + 32'd10);
    step_to(c + 10); chk("R3 third", irq_out, 32'h20);

    // R6 upper comparator cleared by 32-bit mode
    wr(0, 32'h282);
    wr(3, 32'h5); rd(3, r); chk("R6 hi written", r, 32'h5);
    wr(0, 32'h2E6); rd(3, r); chk("R6 hi cleared", r, 32'h0);
    wr(3, 32'h9); rd(3, r); chk("R6 hi ignored", r, 32'h0);

    // R5 / R6 32-bit periodic, counter upper word nonzero
    glb_en = 1'b0;
    wr(0, 32'h2E6);
    step_to(64'h7_0000_0100);
    wr(2, 32'h102);
    wr(2, 32'h8000_0003);
    glb_en = 1'b1;
    step_to(64'h7_0000_0101); chk("R6 early", irq_out, 0);
    step_to(64'h7_0000_0102); chk("R6 match low word", irq_out, 32'h20);
    step_to(64'h7_0000_0103); step_to(64'h7_0000_0104); chk("R5 gap", irq_out, 0);
    step_to(64'h7_0000_0105); chk("R5 masked period", irq_out, 32'h20);

    // R7 wrap pulse then match
    glb_en = 1'b0;
    wr(0, 32'h542);
    step_to(64'h7_FFFF_FFFC);
    glb_en = 1'b1;
    wr(2, 32'h2);
    step_to(64'h7_FFFF_FFFD); step_to(64'h7_FFFF_FFFE); chk("R7 early", irq_out, 0);
    step_to(64'h7_FFFF_FFFF); chk("R7 wrap", irq_out, 32'h400);
    step_to(64'h8_0000_0000); chk("R7 after wrap", irq_out, 0);
    step_to(64'h8_0000_0001);
    step_to(64'h8_0000_0002); chk("R7 match", irq_out, 32'h400);
    step_to(64'h8_0000_0003); chk("R7 done", irq_out, 0);

    // R7 wrap and match in the same cycle
    glb_en = 1'b0;
    step_to(64'h8_FFFF_FFFD);
    glb_en = 1'b1;
    wr(2, 32'hFFFF_FFFF);
    step_to(64'h8_FFFF_FFFE); chk("R7 coincide early", irq_out, 0);
    step_to(64'h8_FFFF_FFFF);
    chk("R7 coincide single", $countones(irq_out), 1);
    chk("R7 coincide line", irq_out, 32'h400);
    step_to(64'h9_0000_0000); chk("R7 coincide next", irq_out, 0);
    step_to(64'h9_0000_0001); step_to(64'h9_0000_0002);
    chk("R7 coincide no repeat", irq_out, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule